// File: doc/BRIEF.md
# Chip-Enable Gate with Bounded Write Grace

This block sits in the active-low chip-enable path between a processor and a battery-backed RAM. While the supply supervisor reports a healthy supply, the gate is open and the RAM sees the processor's chip-enable with no added clock latency. When the supervisor flags a failing supply, the gate closes and drives the RAM's chip-enable to the inactive level. Stray accesses cannot then corrupt retained data.

A write that is already under way when the supervisor flag rises is allowed to finish. The gate stays open until the processor releases chip-enable or until a grace window runs out, whichever comes first. The window length is set in clock cycles, derived from a clock-frequency parameter and a grace time in microseconds. With a 50 MHz clock and 10 µs, the window is 500 cycles.

A two-bit status output reports the gate's condition.

Top module: `ce_guard`

## Requirements
- R1: While the status is open (`2'b01`), `ce_no` equals `ce_ni` combinationally, within the same cycle and with no register in the path.
- R2: If the gate is open and a clock edge samples `sup_rst_i` high with `ce_ni` high, the status becomes closed (`2'b00`) on that edge.
- R3: If the gate is open and a clock edge samples `sup_rst_i` high with `ce_ni` low, the status becomes grace (`2'b10`) on that edge. During grace, `ce_no` follows `ce_ni`.
- R4: In grace, an edge that samples `ce_ni` high while `sup_rst_i` is still high closes the gate.
- R5: If `ce_ni` stays low and `sup_rst_i` stays high, the gate closes on exactly the GRACE_CYC-th edge after the edge that entered grace. GRACE_CYC = CLK_HZ/1e6 × GRACE_US, which is 500 by default.
- R6: While the status is closed, `ce_no` is driven high whatever the value of `ce_ni`.
- R7: Once closed, the gate stays closed on every edge that samples `sup_rst_i` high, even if `ce_ni` falls again.
- R8: The first edge that samples `sup_rst_i` low moves the gate to open, from either closed or grace.
- R9: While `rst_ni` is low, the status is closed and `ce_no` is high. After `rst_ni` is released, the gate opens only through R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset of the block |
| sup_rst_i | input | 1 | Supervisor reset flag, high when the supply is failing |
| ce_ni | input | 1 | Processor chip-enable, active low |
| ce_no | output | 1 | Gated chip-enable to the RAM, active low |
| state_o | output | 2 | Gate status: 00 closed, 01 open, 10 grace |

## Verification
The hardest case to reach is a full grace timeout. It needs the supervisor flag to rise during an active chip-enable, and then both inputs must hold still for 500 cycles. Random toggling of chip-enable almost never produces this. A directed sequence therefore holds chip-enable low across the whole window, counts the grace cycles, and checks that the close falls on the exact edge. Directed cases also cover leaving grace early through a chip-enable release, leaving it through a supervisor release, and a fresh chip-enable after close. Long random runs with held supervisor levels then check every cycle against a bench-side model.

// File: rtl/ce_guard_pkg.sv
package ce_guard_pkg;
  typedef enum logic [1:0] {
    GATE_CLOSED = 2'b00,
    GATE_OPEN   = 2'b01,
    GATE_GRACE  = 2'b10
  } gate_state_e;
endpackage

// File: rtl/ce_guard_timer.sv
module ce_guard_timer #(
  parameter int CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int W = $clog2(CYC + 1);
  localparam logic [W-1:0] LAST = W'(CYC - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  // counter never runs past the final grace cycle
  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_cnt_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/ce_guard_ctrl.sv
module ce_guard_ctrl
  import ce_guard_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sup_rst_i,
  input  logic        ce_ni,
  input  logic        grace_done_i,
  output gate_state_e state_o
);
  gate_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GATE_CLOSED: if (!sup_rst_i) st_d = GATE_OPEN;
      GATE_OPEN:   if (sup_rst_i)  st_d = ce_ni ? GATE_CLOSED : GATE_GRACE;
      GATE_GRACE: begin
        if (!sup_rst_i)                 st_d = GATE_OPEN;
        else if (ce_ni || grace_done_i) st_d = GATE_CLOSED;
      end
      default: st_d = GATE_CLOSED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= GATE_CLOSED;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  assert_close_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == GATE_OPEN && sup_rst_i && ce_ni) |=> st_q == GATE_CLOSED);
  assert_grace_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == GATE_OPEN && sup_rst_i && !ce_ni) |=> st_q == GATE_GRACE);
  assert_grace_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == GATE_GRACE && sup_rst_i && ce_ni) |=> st_q == GATE_CLOSED);
  assert_stay_closed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == GATE_CLOSED && sup_rst_i) |=> st_q == GATE_CLOSED);
  assert_reopen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != GATE_OPEN && !sup_rst_i) |=> st_q == GATE_OPEN);
endmodule

// File: rtl/ce_guard_drive.sv
module ce_guard_drive
  import ce_guard_pkg::*;
(
  input  gate_state_e state_i,
  input  logic        ce_ni,
  output logic        ce_no
);
  // pass path is pure logic; closed state forces the inactive level
  assign ce_no = (state_i == GATE_CLOSED) ? 1'b1 : ce_ni;
endmodule

// File: rtl/ce_guard.sv
module ce_guard
  import ce_guard_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int GRACE_US = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sup_rst_i,
  input  logic       ce_ni,
  output logic       ce_no,
  output logic [1:0] state_o
);
  localparam int RAW_CYC   = (CLK_HZ / 1_000_000) * GRACE_US;
  localparam int GRACE_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

  gate_state_e st;
  logic        grace_done;

  ce_guard_timer #(.CYC(GRACE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st == GATE_GRACE),
    .done_o (grace_done)
  );

  ce_guard_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sup_rst_i    (sup_rst_i),
    .ce_ni        (ce_ni),
    .grace_done_i (grace_done),
    .state_o      (st)
  );

  ce_guard_drive u_drive (
    .state_i (st),
    .ce_ni   (ce_ni),
    .ce_no   (ce_no)
  );

  assign state_o = st;

  always_comb begin
    if (!rst_ni) assert_por_closed_R9: assert (ce_no == 1'b1);
  end

  assert_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != GATE_CLOSED) |-> ce_no == ce_ni);
  assert_block_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == GATE_CLOSED) |-> ce_no);
  assert_timeout_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == GATE_GRACE && grace_done && sup_rst_i) |=> st == GATE_CLOSED);
endmodule

// File: tb/ce_guard_tb.sv
module ce_guard_tb;
  localparam int GRACE = 50 * 10;  // 50 MHz x 10 us

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sr = 1'b1;
  logic       ce = 1'b1;
  logic       ce_no;
  logic [1:0] st;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [1:0] m_st = 2'b00;
  int         m_cnt = 0;

  always #10 clk = ~clk;

  ce_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sup_rst_i(sr), .ce_ni(ce),
    .ce_no(ce_no), .state_o(st)
  );

  function automatic logic exp_out(input logic [1:0] s, input logic c);
    return (s == 2'b00) ? 1'b1 : c;
  endfunction

  function automatic string auto_tag(input logic [1:0] s);
    if (s == 2'b00) return "R6";
    if (s == 2'b01) return "R1";
    return "R3";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    case (m_st)
      2'b00: if (!sr) m_st = 2'b01;
      2'b01: if (sr) begin m_st = ce ? 2'b00 : 2'b10; m_cnt = 0; end
      default: begin
        if (!sr) m_st = 2'b01;
        else if (ce) m_st = 2'b00;
        else if (m_cnt == GRACE - 1) m_st = 2'b00;
        else m_cnt++;
      end
    endcase
  endtask

  // apply inputs, check combinational output and status, then clock
  task automatic cyc(input logic s_in, input logic c_in, input string tag);
    string t;
    sr = s_in; ce = c_in;
    #1;
    t = (tag == "") ? auto_tag(m_st) : tag;
    chk(t, {31'd0, ce_no}, {31'd0, exp_out(m_st, ce)});
    chk(t, {30'd0, st}, {30'd0, m_st});
    @(posedge clk);
    model_edge();
    #2;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R9: reset state
    #5;
    chk("R9", {31'd0, ce_no}, 32'd1);
    chk("R9", {30'd0, st}, 32'd0);
    ce = 1'b0; #1;
    chk("R9", {31'd0, ce_no}, 32'd1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    // R9: stays closed while supervisor flag high
    for (int i = 0; i < 4; i++) cyc(1'b1, i[0], "R9");
    // R8: first edge with flag low opens
    cyc(1'b0, 1'b1, "R8");
    chk("R8", {30'd0, st}, 32'd1);
    // R1: pass-through both levels
    for (int i = 0; i < 6; i++) cyc(1'b0, i[0], "R1");
    // R2: flag with ce idle closes at once
    cyc(1'b1, 1'b1, "R2");
    chk("R2", {30'd0, st}, 32'd0);
    // R6/R7: new ce low ignored while closed
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, "R7");
    chk("R6", {31'd0, ce_no}, 32'd1);
    cyc(1'b0, 1'b1, "R8");
    // R3/R4: grace then release by ce
    cyc(1'b0, 1'b0, "R1");
    cyc(1'b1, 1'b0, "R3");
    chk("R3", {30'd0, st}, 32'd2);
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, "R3");
    cyc(1'b1, 1'b1, "R4");
    chk("R4", {30'd0, st}, 32'd0);
    // R8 from grace
    cyc(1'b0, 1'b1, "R8");
    cyc(1'b0, 1'b0, "R1");
    cyc(1'b1, 1'b0, "R3");
    cyc(1'b0, 1'b0, "R8");
    chk("R8", {30'd0, st}, 32'd1);
    // R5: full timeout, count grace cycles
    begin
      int g = 0;
      cyc(1'b1, 1'b0, "R3");
      while (st == 2'b10 && g < GRACE + 10) begin
        g++;
        cyc(1'b1, 1'b0, "R5");
      end
      chk("R5", g, GRACE);
      chk("R5", {30'd0, st}, 32'd0);
      chk("R6", {31'd0, ce_no}, 32'd1);
    end
    // random phase
    begin
      logic s_r = 1'b0, c_r = 1'b1;
      for (int i = 0; i < 20000; i++) begin
        if ($urandom_range(49) == 0) s_r = ~s_r;
        if ($urandom_range(3) == 0)  c_r = ~c_r;
        cyc(s_r, c_r, "");
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule